// File: doc/BRIEF.md
# Register-Programmed Clock Rate Divider

The block divides one input clock by a whole number taken from a bit field of a 32-bit control word. The word is loaded by a write strobe. A parameter picks how the field is turned into a divisor: field plus one, the field itself, two raised to the field, or an index into a small parameter table in which a zero entry marks a forbidden index. The output is never gated by the divider itself. Divide-by-1 passes the input clock straight through, and larger divisors come from a counter.

A write whose field decodes to a forbidden or out-of-range divisor raises an error flag and leaves the running divisor alone. A new legal divisor waits until the current output period has ended, so the output never shows a shortened pulse. When a commit bit is configured, a write changes the divisor only if that bit is set in the same word. A separate enable bit, with a selectable polarity, lets an idle request input hold the output low from the next period boundary until the request drops.

Top module: `clk_rate_div`

## Requirements
- R1: With MODE=0 the divisor is the field value plus one. It is legal only between MIN_DIV and MAX_DIV; field 0 divides by 1 and field 6 by 7.
- R2: With MODE=1 the divisor equals the field value. A field of 0 is illegal, and so is any value outside MIN_DIV..MAX_DIV.
- R3: With MODE=2 the divisor is 2 to the power of the field value (field 2 gives 4, field 0 gives 1). A result above MAX_DIV is illegal.
- R4: With MODE=3 the field indexes the table TAB. An index whose entry is 0, or an index at or beyond TAB_N, is illegal. MIN_DIV and MAX_DIV are not applied.
- R5: The field is the FIELD_W bits starting at bit FIELD_LSB of wr_data. Bits outside the field, the commit bit and the idle bit have no effect on the divisor.
- R6: On the clock edge of a write, div_err becomes 1 if the write is illegal and 0 if it is legal. An illegal write leaves the running divisor unchanged. Without a write, div_err holds its value.
- R7: With LATCH_EN=1, a legal write changes the divisor only when bit LATCH_BIT of wr_data is 1. With LATCH_EN=0, every legal write changes it.
- R8: For divisor N>1, clk_out has a period of N input cycles and is high for the first floor(N/2) of them. For N=1, clk_out equals clk_in. A new divisor takes effect only at the end of an output period.
- R9: On each write, the idle enable is loaded from wr_data[IDLE_BIT], inverted when IDLE_INV=1. While the enable is set and idle_req is high, clk_out is held low from the next period end. It resumes at a period end after idle_req falls. A disabled enable makes idle_req have no effect.
- R10: Reset sets the divisor to RST_DIV and div_err to 0. It also sets the idle enable to the value a 0 in the idle bit would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Strobe that loads wr_data as the control word |
| wr_data | input | 32 | Control word: divisor field, commit bit, idle enable bit |
| idle_req | input | 1 | Request to hold the output low when idle is enabled |
| clk_out | output | 1 | Divided clock |
| div_err | output | 1 | Set by an illegal write, cleared by a legal one |

## Verification
div_err is due on the rising input edge that takes the write, so the bench reads it at the falling edge that ends the strobe. A divisor change is due only after the current output period ends, which can take up to MAX_DIV input cycles. The idle hold is likewise due only after a period end. The bench therefore waits 60 input cycles after each write or idle change before it looks at clk_out. It then samples clk_out one nanosecond after every input edge and measures the high time and period in half-cycles from one clean rising transition. This makes each check independent of the exact boundary cycle.

// File: rtl/clk_rate_div.sv
module clk_rate_div #(
  parameter int MODE      = 0,
  parameter int FIELD_LSB = 0,
  parameter int FIELD_W   = 8,
  parameter int MIN_DIV   = 1,
  parameter int MAX_DIV   = 127,
  parameter int RST_DIV   = 1,
  parameter int LATCH_EN  = 0,
  parameter int LATCH_BIT = 31,
  parameter int IDLE_BIT  = 16,
  parameter int IDLE_INV  = 0,
  parameter int TAB_N     = 4,
  parameter int TAB [TAB_N] = '{4, 8, 0, 16}
) (
  input  logic        clk_in,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        idle_req,
  output logic        clk_out,
  output logic        div_err
);
  localparam int DW = $clog2(MAX_DIV + 1);

  logic [FIELD_W-1:0] fld;
  logic [31:0]        dec;
  logic               ok;
  logic [DW-1:0]      cur, cnt, pdiv, div_nx, cnt_nx;
  logic               pend, q, hold, idle_en, wrap, commit;

  assign fld = wr_data[FIELD_LSB +: FIELD_W];

  always_comb begin
    dec = '0;
    ok  = 1'b0;
    case (MODE)
      1: begin
        dec = 32'(fld);
        ok  = (fld != '0);
      end
      2: begin
        ok = (32'(fld) < 32'd31);
        if (ok) dec = 32'd1 << fld;
      end
      3: begin
        for (int i = 0; i < TAB_N; i++)
          if (int'(fld) == i) begin
            dec = 32'(TAB[i]);
            ok  = (TAB[i] != 0);
          end
      end
      default: begin
        dec = 32'(fld) + 32'd1;
        ok  = 1'b1;
      end
    endcase
    if (MODE != 3)
      ok = ok && (dec >= 32'(MIN_DIV)) && (dec <= 32'(MAX_DIV));
  end

  assign commit = wr_en && ok && ((LATCH_EN == 0) || wr_data[LATCH_BIT]);
  assign wrap   = (cnt == DW'(cur - 1'b1));
  assign div_nx = (wrap && pend) ? pdiv : cur;
  assign cnt_nx = wrap ? '0 : DW'(cnt + 1'b1);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= DW'(RST_DIV);
      cnt     <= '0;
      pdiv    <= '0;
      pend    <= 1'b0;
      q       <= 1'b0;
      hold    <= 1'b0;
      div_err <= 1'b0;
      idle_en <= (IDLE_INV != 0);
    end else begin
      if (wr_en) begin
        div_err <= !ok;
        idle_en <= wr_data[IDLE_BIT] ^ (IDLE_INV != 0);
      end
      if (commit) begin
        pend <= 1'b1;
        pdiv <= DW'(dec);
      end else if (wrap) begin
        pend <= 1'b0;
      end
      if (wrap) begin
        hold <= idle_en && idle_req;
        cur  <= div_nx;
      end
      cnt <= cnt_nx;
      q   <= (cnt_nx < (div_nx >> 1));
    end
  end

  assign clk_out = hold ? 1'b0 : ((cur == DW'(1)) ? clk_in : q);
endmodule

// File: rtl/clk_rate_div_chk.sv
module clk_rate_div_chk #(
  parameter int DW        = 7,
  parameter int MAX_DIV   = 127,
  parameter int LATCH_EN  = 0,
  parameter int LATCH_BIT = 31
) (
  input logic          clk_in,
  input logic          rst_n,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic [DW-1:0] cur,
  input logic [DW-1:0] cnt,
  input logic          pend,
  input logic          hold,
  input logic          div_err
);
  assert_cur_legal_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cur != '0) && (32'(cur) <= 32'(MAX_DIV)));

  assert_count_in_period_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt < cur);

  assert_switch_at_end_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(cur) |-> ($past(cnt) == DW'($past(cur) - 1'b1)));

  assert_err_on_write_only_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(div_err));

  assert_latch_gate_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    ((LATCH_EN != 0) && wr_en && !wr_data[LATCH_BIT] && !pend) |=> !pend);

  assert_hold_at_end_R9: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($rose(hold) || $fell(hold)) |-> ($past(cnt) == DW'($past(cur) - 1'b1)));
endmodule

bind clk_rate_div clk_rate_div_chk #(
  .DW(DW), .MAX_DIV(MAX_DIV), .LATCH_EN(LATCH_EN), .LATCH_BIT(LATCH_BIT)
) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .cur(cur), .cnt(cnt), .pend(pend), .hold(hold), .div_err(div_err)
);

// File: tb/clk_rate_div_test.sv
module clk_rate_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  we = '0;
  logic [31:0] wd = '0;
  logic        idle_req = 1'b0;
  logic [3:0]  co, er;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  // 0: plus-one, field at bit 4, idle bit 16
  clk_rate_div #(.MODE(0), .FIELD_LSB(4), .FIELD_W(8)) uut (
    .clk_in(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_data(wd),
    .idle_req(idle_req), .clk_out(co[0]), .div_err(er[0]));
  // 1: direct, range 2..12
  clk_rate_div #(.MODE(1), .FIELD_LSB(0), .FIELD_W(4), .MIN_DIV(2), .MAX_DIV(12),
    .RST_DIV(2)) u_dir (
    .clk_in(clk), .rst_n(rst_n), .wr_en(we[1]), .wr_data(wd),
    .idle_req(idle_req), .clk_out(co[1]), .div_err(er[1]));
  // 2: power of two, field at bit 8, idle bit 0 inverted
  clk_rate_div #(.MODE(2), .FIELD_LSB(8), .FIELD_W(3), .MAX_DIV(16),
    .IDLE_BIT(0), .IDLE_INV(1)) u_pow (
    .clk_in(clk), .rst_n(rst_n), .wr_en(we[2]), .wr_data(wd),
    .idle_req(idle_req), .clk_out(co[2]), .div_err(er[2]));
  // 3: table {4,8,0,16}, field at bit 24, commit bit 31
  clk_rate_div #(.MODE(3), .FIELD_LSB(24), .FIELD_W(2), .MAX_DIV(16), .RST_DIV(4),
    .LATCH_EN(1), .LATCH_BIT(31)) u_tab (
    .clk_in(clk), .rst_n(rst_n), .wr_en(we[3]), .wr_data(wd),
    .idle_req(idle_req), .clk_out(co[3]), .div_err(er[3]));

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] data;
    logic [7:0]  div;
    logic        err;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h0000_0030, 8'd4,  1'b0},  // R1
    '{2'd0, 32'h0000_000F, 8'd1,  1'b0},  // R1 R5 low bits ignored
    '{2'd0, 32'h0000_0060, 8'd7,  1'b0},  // R1 odd divisor
    '{2'd0, 32'h0000_0C80, 8'd7,  1'b1},  // R1 R6 201 > MAX
    '{2'd1, 32'h0000_0001, 8'd2,  1'b1},  // R2 R6 below MIN
    '{2'd1, 32'h0000_0005, 8'd5,  1'b0},  // R2
    '{2'd2, 32'h0000_0200, 8'd4,  1'b0},  // R3
    '{2'd2, 32'h0000_0500, 8'd4,  1'b1},  // R3 R6 32 > MAX
    '{2'd2, 32'h0000_0000, 8'd1,  1'b0},  // R3
    '{2'd3, 32'h0300_0000, 8'd4,  1'b0},  // R7 no commit bit
    '{2'd3, 32'h8300_0000, 8'd16, 1'b0},  // R4 R7 committed
    '{2'd3, 32'h8200_0000, 8'd16, 1'b1},  // R4 R6 zero entry
    '{2'd3, 32'h8100_0000, 8'd8,  1'b0}   // R4
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic half(input int s, output logic v);
    @(clk);
    #1;
    v = co[s];
  endtask

  task automatic measure(input int s, output int hi, output int per);
    logic v;
    int   n;
    hi = -1; per = -1;
    n = 0;
    do begin half(s, v); n++; end while (v && n < 1000);
    do begin half(s, v); n++; end while (!v && n < 1000);
    if (n >= 1000) return;
    hi = 1;
    do begin half(s, v); if (v) hi++; end while (v && hi < 1000);
    per = hi + 1;
    do begin half(s, v); if (!v) per++; end while (!v && per < 1000);
  endtask

  task automatic check_div(input string tag, input int s, input int d);
    int hi, per;
    measure(s, hi, per);
    chk({tag, " period"}, per, 2 * d);
    chk({tag, " high"}, hi, (d == 1) ? 1 : 2 * (d / 2));
  endtask

  task automatic check_low(input string tag, input int s);
    logic v;
    int   seen = 0;
    for (int i = 0; i < 48; i++) begin half(s, v); if (v) seen++; end
    chk(tag, seen, 0);
  endtask

  task automatic write(input int s, input logic [31:0] d);
    @(negedge clk);
    wd = d;
    we[s] = 1'b1;
    @(negedge clk);
    we[s] = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    for (int s = 0; s < 4; s++) chk("R10 err after reset", er[s], 0);
    check_div("R10 reset div uut", 0, 1);
    check_div("R10 reset div dir", 1, 2);
    check_div("R10 reset div pow", 2, 1);
    check_div("R10 reset div tab", 3, 4);

    // vector walk: R1..R8
    for (int i = 0; i < NV; i++) begin
      write(int'(VEC[i].sel), VEC[i].data);
      chk($sformatf("R6 vector %0d err", i), er[VEC[i].sel], int'(VEC[i].err));
      settle();
      check_div($sformatf("R8 vector %0d", i), int'(VEC[i].sel), int'(VEC[i].div));
    end

    // R6 legal write clears the flag
    write(3, 32'h8000_0000);
    chk("R6 legal write clears err", er[3], 0);
    settle();
    check_div("R4 table index 0", 3, 4);

    // R9 idle: uut disabled, u_pow enabled by inverted 0 bit
    write(0, 32'h0000_0030);
    idle_req = 1'b1;
    settle();
    check_div("R9 idle ignored when disabled", 0, 4);
    check_low("R9 inverted enable holds low", 2);
    write(0, 32'h0001_0030);
    settle();
    check_low("R9 enabled idle holds low", 0);
    idle_req = 1'b0;
    settle();
    check_div("R9 resume after idle", 0, 4);
    check_div("R9 resume div1", 2, 1);
    write(2, 32'h0000_0001);
    idle_req = 1'b1;
    settle();
    check_div("R9 inverted bit set disables", 2, 1);
    idle_req = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule